// File: doc/BRIEF.md
# Dual-Bank Quad-SPI Target Decoder

This block is the receive side of a quad-SPI target that listens on two banks of four data lines at once. The host lowers an active-low select and clocks a transaction. First comes an 8-bit opcode, sent one bit per clock on line 0 of bank A. Next comes a 24-bit address, sent one nibble per clock on bank A, and then two idle clocks. After that, every pair of clocks carries one nibble pair on each bank, and the two nibble pairs form one 16-bit word. Words keep arriving for as long as the select stays low.

All decoded values are produced in the serial clock domain. They are pushed, in order, through a small gray-coded asynchronous FIFO, so they can be presented in an unrelated system clock domain. On the system side the command, the address and each word appear on their own output bus, each with a one-cycle strobe. When the opcode asks for a read, the block raises a pad output-enable for the data phase, so that the pads can turn around. The pad buffers are outside this block.

Top module: `qspi_dual_decoder`

## Requirements
- R1: The opcode is the 8 bits on bank A line 0, most significant bit first, one bit per rising serial clock. Lines 1 to 3 of both banks are ignored during this phase. When it is complete, `cmd_valid` pulses with the opcode on `cmd_data`.
- R2: The address is the next 6 clocks of bank A, taken as nibbles. Line 3 is each nibble's top bit, and the first nibble is the address's top nibble. When it is complete, `addr_valid` pulses with the 24-bit value on `addr_data`.
- R3: Exactly 2 clocks follow the address and are discarded, whatever the lines carry. The data phase starts on the third clock after the address.
- R4: In the data phase a word takes two clocks, high nibbles first. `word_data` = {bank A byte, bank B byte}, so bank A supplies bits 15:8. Each word pulses `word_valid` once.
- R5: Words continue with no burst limit while `cs_n` stays low.
- R6: Raising `cs_n` at any point aborts the transaction and returns the decoder to the opcode phase. An address or word left incomplete is never strobed, and the next transaction decodes normally.
- R7: An opcode with bit 7 set is a read. `pad_oe` goes high after the second dummy clock, stays high through the data phase and drops as soon as `cs_n` rises. A read delivers no words.
- R8: For an opcode with bit 7 clear, `pad_oe` stays low for the whole transaction.
- R9: Each strobe is high for exactly one system cycle, and at most one strobe is high at a time. Each output bus holds its value until its next strobe.
- R10: While `sys_rst_n` is low at a system clock edge, all strobes and output buses are zero. Decoding resumes with the next transaction after release.
- R11: The system side sees the opcode, then the address, then the words, in arrival order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high holds the serial side in reset |
| bank_a_io | input | 4 | Bank A data lines (line 0 carries the opcode) |
| bank_b_io | input | 4 | Bank B data lines |
| pad_oe | output | 1 | Pad turnaround enable for read data phases |
| cmd_valid | output | 1 | One-cycle strobe: opcode received |
| cmd_data | output | 8 | Last received opcode |
| addr_valid | output | 1 | One-cycle strobe: address received |
| addr_data | output | 24 | Last received address |
| word_valid | output | 1 | One-cycle strobe: data word received |
| word_data | output | 16 | Last received data word |

## Verification
The bench drives nonzero values on the unused lines during the opcode phase and all-ones during the dummy clocks. A decoder that took in stray lines, or that had the wrong number of dummy clocks, would produce shifted or corrupted words. Transactions are aborted in the middle of the address and in the middle of a word. A decoder that failed to reset its phase counter on deselect would strobe partial fields, or would misframe the next opcode. A read is checked clock by clock for the moment `pad_oe` rises, and for any words leaking out while the target owns the lines. A system reset is applied between transactions to confirm that the buses clear and that the crossing recovers afterwards.

// File: rtl/qdd_pkg.sv
// Shared constants and types for the dual-bank quad-SPI target decoder.
// Assumes the address is the widest field, so it sets the payload width.
package qdd_pkg;
    localparam int LANES      = 4;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_NIBS  = 6;
    localparam int DUMMY_CLKS = 2;
    localparam int READ_BIT   = 7;

    localparam int ADDR_BITS  = ADDR_NIBS * LANES;
    localparam int BYTE_BITS  = 2 * LANES;
    localparam int WORD_BITS  = 2 * BYTE_BITS;
    localparam int PAYLOAD_W  = ADDR_BITS;
    localparam int CNT_W      = $clog2(CMD_BITS + ADDR_NIBS + DUMMY_CLKS);

    typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;
    typedef enum logic [1:0] {TAG_NONE, TAG_CMD, TAG_ADDR, TAG_WORD} tag_e;

    typedef struct packed {
        tag_e                 tag;
        logic [PAYLOAD_W-1:0] payload;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/qdd_bit_sync.sv
// Two-flop synchronizer for a vector that is already safe to sample bit by bit
// (gray pointers, a constant). The parameter ASYNC_RST picks the reset variant:
// an asynchronous assert (for the serial domain, whose clock may stop) or a
// synchronous active-low reset.
module qdd_bit_sync #(
    parameter int W         = 1,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    logic [W-1:0] s2;

    generate
        if (ASYNC_RST) begin : g_async
            // Two-stage resampling, cleared as soon as reset asserts.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= '0;
                    s2 <= '0;
                end else begin
                    s1 <= d;
                    s2 <= s1;
                end
            end
        end else begin : g_sync
            // Two-stage resampling, cleared on a clock edge under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= '0;
                    s2 <= '0;
                end else begin
                    s1 <= d;
                    s2 <= s1;
                end
            end
        end
    endgenerate

    assign q = s2;
endmodule

// File: rtl/qdd_serial_rx.sv
// Serial-clock side: sequences the opcode, address, dummy and data phases,
// builds each field from the lines sampled on rising sck, and requests a FIFO
// push on the very edge a field completes, so a field that ends on the final
// clock is not lost. Assumes cs_n is the only reset of this logic: while the
// select is high, the state is held cleared regardless of sck.
module qdd_serial_rx
    import qdd_pkg::*;
(
    input  logic             sck,
    input  logic             cs_n,
    input  logic [LANES-1:0] a_io,
    input  logic [LANES-1:0] b_io,
    output logic             push,
    output entry_t           push_entry,
    output logic             oe
);
    phase_e               phase;
    logic [CNT_W-1:0]     cnt;
    logic [CMD_BITS-1:0]  cmd_sr;
    logic [ADDR_BITS-1:0] addr_sr;
    logic [LANES-1:0]     a_hi;
    logic [LANES-1:0]     b_hi;
    logic                 half;
    logic                 is_read;

    logic [CMD_BITS-1:0]  cmd_next;
    logic [ADDR_BITS-1:0] addr_next;
    logic [WORD_BITS-1:0] word_next;

    assign cmd_next  = {cmd_sr[CMD_BITS-2:0], a_io[0]};
    assign addr_next = {addr_sr[ADDR_BITS-LANES-1:0], a_io};
    assign word_next = {a_hi, a_io, b_hi, b_io};

    // Push request and entry for the field completing on this edge.
    always_comb begin
        push       = 1'b0;
        push_entry = '{tag: TAG_NONE, payload: '0};
        case (phase)
            PH_CMD: if (cnt == CNT_W'(CMD_BITS - 1)) begin
                push       = 1'b1;
                push_entry = '{tag: TAG_CMD, payload: PAYLOAD_W'(cmd_next)};
            end
            PH_ADDR: if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
                push       = 1'b1;
                push_entry = '{tag: TAG_ADDR, payload: addr_next};
            end
            PH_DATA: if (half && !is_read) begin
                push       = 1'b1;
                push_entry = '{tag: TAG_WORD, payload: PAYLOAD_W'(word_next)};
            end
            default: ;
        endcase
    end

    // Phase sequencing and field assembly; deselect clears everything.
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            phase   <= PH_CMD;
            cnt     <= '0;
            cmd_sr  <= '0;
            addr_sr <= '0;
            a_hi    <= '0;
            b_hi    <= '0;
            half    <= 1'b0;
            is_read <= 1'b0;
            oe      <= 1'b0;
        end else begin
            case (phase)
                PH_CMD: begin
                    cmd_sr <= cmd_next;
                    if (cnt == CNT_W'(CMD_BITS - 1)) begin
                        phase   <= PH_ADDR;
                        cnt     <= '0;
                        is_read <= cmd_next[READ_BIT];
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_ADDR: begin
                    addr_sr <= addr_next;
                    if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
                        phase <= PH_DUMMY;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_DUMMY: begin
                    if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                        half  <= 1'b0;
                        oe    <= is_read;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    half <= ~half;
                    if (!half) begin
                        a_hi <= a_io;
                        b_hi <= b_io;
                    end
                end
            endcase
        end
    end

    AST_OE_ONLY_READ: assert property (@(posedge sck) disable iff (cs_n)
        oe |-> is_read) else $error("oe without read opcode");           // R7
    AST_OE_DATA_ONLY: assert property (@(posedge sck) disable iff (cs_n)
        oe |-> (phase == PH_DATA)) else $error("oe outside data phase"); // R7
    AST_DUMMY_EXIT: assert property (@(posedge sck) disable iff (cs_n)
        (phase == PH_DUMMY) |=> (phase inside {PH_DUMMY, PH_DATA}))
        else $error("dummy phase left wrongly");                          // R3
endmodule

// File: rtl/qdd_cdc_fifo.sv
// Small asynchronous FIFO with gray-coded pointers. The write side runs on a
// clock that may stop between transactions and has an asynchronous reset.
// The read side uses a synchronous active-low reset. Assumes AW >= 2.
module qdd_cdc_fifo #(
    parameter int WIDTH = 8,
    parameter int AW    = 2
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wbin;
    logic [AW:0]      wgray;
    logic [AW:0]      rbin;
    logic [AW:0]      rgray;
    logic [AW:0]      rgray_w;
    logic [AW:0]      wgray_r;
    logic [AW:0]      wbin_next;
    logic [AW:0]      rbin_next;
    logic             wr_do;
    logic             rd_do;

    assign wr_do     = wr_req && !full;
    assign rd_do     = rd_en && !empty;
    assign wbin_next = wbin + (AW+1)'(wr_do);
    assign rbin_next = rbin + (AW+1)'(rd_do);
    assign full      = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign empty     = (rgray == wgray_r);
    assign rdata     = mem[rbin[AW-1:0]];

    // Storage write on the serial clock.
    always_ff @(posedge wclk) begin
        if (wr_do) mem[wbin[AW-1:0]] <= wdata;
    end

    // Write pointer in binary and gray form.
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_next;
            wgray <= wbin_next ^ (wbin_next >> 1);
        end
    end

    // Read pointer in binary and gray form.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_next;
            rgray <= rbin_next ^ (rbin_next >> 1);
        end
    end

    qdd_bit_sync #(.W(AW+1), .ASYNC_RST(1'b1)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
    qdd_bit_sync #(.W(AW+1), .ASYNC_RST(1'b0)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_req |-> !full) else $error("push into full fifo");            // R11
endmodule

// File: rtl/qspi_dual_decoder.sv
// Top of the dual-bank quad-SPI target decoder. It joins the serial
// receiver, the crossing FIFO and the system-side unpacker, which turns each
// popped entry into a one-cycle strobe on its own bus. Assumes sys_clk
// drains the FIFO faster than fields arrive, which holds when it is not much
// slower than sck.
module qspi_dual_decoder
    import qdd_pkg::*;
#(
    parameter int FIFO_AW = 2
) (
    input  logic                 sys_clk,
    input  logic                 sys_rst_n,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic [LANES-1:0]     bank_a_io,
    input  logic [LANES-1:0]     bank_b_io,
    output logic                 pad_oe,
    output logic                 cmd_valid,
    output logic [CMD_BITS-1:0]  cmd_data,
    output logic                 addr_valid,
    output logic [ADDR_BITS-1:0] addr_data,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_data
);
    logic   push;
    entry_t push_entry;
    logic   fifo_full;
    logic   fifo_empty;
    logic   wr_rst_n;
    logic   [ENTRY_W-1:0] pop_raw;
    entry_t pop;

    // Carry the system reset into the serial domain (asynchronous assert).
    qdd_bit_sync #(.W(1), .ASYNC_RST(1'b1)) u_wrst (
        .clk(sck), .rst_n(sys_rst_n), .d(1'b1), .q(wr_rst_n));

    qdd_serial_rx u_rx (
        .sck(sck), .cs_n(cs_n), .a_io(bank_a_io), .b_io(bank_b_io),
        .push(push), .push_entry(push_entry), .oe(pad_oe));

    qdd_cdc_fifo #(.WIDTH(ENTRY_W), .AW(FIFO_AW)) u_fifo (
        .wclk(sck), .wrst_n(wr_rst_n), .wr_req(push), .wdata(push_entry),
        .full(fifo_full), .rclk(sys_clk), .rrst_n(sys_rst_n),
        .rd_en(!fifo_empty), .rdata(pop_raw), .empty(fifo_empty));

    assign pop = entry_t'(pop_raw);

    // Pop one entry per cycle and route it to its bus with a strobe.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            cmd_valid  <= 1'b0;
            addr_valid <= 1'b0;
            word_valid <= 1'b0;
            cmd_data   <= '0;
            addr_data  <= '0;
            word_data  <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            addr_valid <= 1'b0;
            word_valid <= 1'b0;
            if (!fifo_empty) begin
                case (pop.tag)
                    TAG_CMD: begin
                        cmd_data  <= pop.payload[CMD_BITS-1:0];
                        cmd_valid <= 1'b1;
                    end
                    TAG_ADDR: begin
                        addr_data  <= pop.payload;
                        addr_valid <= 1'b1;
                    end
                    TAG_WORD: begin
                        word_data  <= pop.payload[WORD_BITS-1:0];
                        word_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $onehot0({cmd_valid, addr_valid, word_valid}))
        else $error("strobes overlap");                                   // R9
    AST_CMD_PULSE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cmd_valid |=> !cmd_valid) else $error("long cmd strobe");        // R9
    AST_ADDR_PULSE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        addr_valid |=> !addr_valid) else $error("long addr strobe");     // R9
    AST_DESELECT_OE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cs_n |-> !pad_oe) else $error("oe while deselected");            // R7
endmodule

// File: tb/test_qspi_dual_decoder.sv
module test_qspi_dual_decoder;
    logic        sys_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b0;
    logic [3:0]  bank_a_io = '0;
    logic [3:0]  bank_b_io = '0;
    logic        pad_oe;
    logic        cmd_valid, addr_valid, word_valid;
    logic [7:0]  cmd_data;
    logic [23:0] addr_data;
    logic [15:0] word_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int ev_n = 0;
    int ev_kind [32];
    logic [23:0] ev_val [32];
    int strobe_err = 0;
    bit oe_seen = 1'b0;
    logic p_cmd = 1'b0, p_addr = 1'b0, p_word = 1'b0;

    // {opcode, address, word 0, word 1}; opcodes are writes (bit 7 clear)
    localparam logic [63:0] VEC [4] = '{
        {8'h02, 24'h123456, 16'hA55A, 16'h0F0F},
        {8'h7F, 24'hFFFFFF, 16'hFFFF, 16'h0000},
        {8'h00, 24'h000000, 16'h0000, 16'h8001},
        {8'h55, 24'hABCDEF, 16'h1234, 16'hFEDC}
    };

    qspi_dual_decoder i_qspi_dual_decoder (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .sck(sck), .cs_n(cs_n),
        .bank_a_io(bank_a_io), .bank_b_io(bank_b_io), .pad_oe(pad_oe),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .addr_valid(addr_valid), .addr_data(addr_data),
        .word_valid(word_valid), .word_data(word_data));

    always #2 sys_clk = ~sys_clk;

    // Record strobes and pulse-shape violations away from the active edge.
    always @(negedge sys_clk) begin
        if (sys_rst_n) begin
            if ((32'(cmd_valid) + 32'(addr_valid) + 32'(word_valid)) > 1) strobe_err++;
            if ((cmd_valid && p_cmd) || (addr_valid && p_addr) || (word_valid && p_word))
                strobe_err++;
            if (cmd_valid && ev_n < 32) begin
                ev_kind[ev_n] = 1; ev_val[ev_n] = 24'(cmd_data); ev_n++;
            end
            if (addr_valid && ev_n < 32) begin
                ev_kind[ev_n] = 2; ev_val[ev_n] = addr_data; ev_n++;
            end
            if (word_valid && ev_n < 32) begin
                ev_kind[ev_n] = 3; ev_val[ev_n] = 24'(word_data); ev_n++;
            end
        end
        if (pad_oe) oe_seen = 1'b1;
        p_cmd = cmd_valid; p_addr = addr_valid; p_word = word_valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int idx, input int kind, input logic [23:0] val,
                             input string req);
        chk({req, " kind"}, 32'(ev_kind[idx]), 32'(kind));
        chk({req, " value"}, 32'(ev_val[idx]), 32'(val));
    endtask

    task automatic sck_pulse(input logic [3:0] a, input logic [3:0] b);
        bank_a_io = a; bank_b_io = b;
        #4 sck = 1'b1;
        #8 sck = 1'b0;
        #4;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 7; i >= 0; i--) sck_pulse({3'b101, c[i]}, 4'b0110);
    endtask

    task automatic send_addr(input logic [23:0] ad, input int nibs);
        for (int i = 0; i < nibs; i++) sck_pulse(ad[23-4*i -: 4], 4'h9);
    endtask

    task automatic send_dummy(input int n);
        for (int i = 0; i < n; i++) sck_pulse(4'hF, 4'hF);
    endtask

    task automatic send_word(input logic [15:0] w);
        sck_pulse(w[15:12], w[7:4]);
        sck_pulse(w[11:8], w[3:0]);
    endtask

    task automatic begin_txn();
        for (int i = 0; i < 32; i++) begin ev_kind[i] = 0; ev_val[i] = '0; end
        ev_n = 0; oe_seen = 1'b0;
        cs_n = 1'b0;
        #4;
    endtask

    task automatic end_txn();
        #2 cs_n = 1'b1;
        #200;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1 cs_n = 1'b1;
        #20 sys_rst_n = 1'b1;
        #20;
        // R10: reset state
        chk("R10 cmd_data after reset", 32'(cmd_data), 0);
        chk("R10 addr_data after reset", 32'(addr_data), 0);
        chk("R10 word_data after reset", 32'(word_data), 0);
        chk("R10 strobes after reset", {29'd0, cmd_valid, addr_valid, word_valid}, 0);
        chk("R7 pad_oe idle", 32'(pad_oe), 0);

        // Table of write transactions: R1 R2 R3 R4 R8 R11
        for (int v = 0; v < 4; v++) begin
            begin_txn();
            send_cmd(VEC[v][63:56]);
            send_addr(VEC[v][55:32], 6);
            send_dummy(2);
            send_word(VEC[v][31:16]);
            send_word(VEC[v][15:0]);
            end_txn();
            chk("R11 event count", 32'(ev_n), 4);
            expect_ev(0, 1, 24'(VEC[v][63:56]), "R1 opcode");
            expect_ev(1, 2, VEC[v][55:32], "R2 address");
            expect_ev(2, 3, 24'(VEC[v][31:16]), "R4 word0 R3");
            expect_ev(3, 3, 24'(VEC[v][15:0]), "R4 word1");
            chk("R8 oe low on write", 32'(oe_seen), 0);
        end

        // R5: long burst
        begin_txn();
        send_cmd(8'h40);
        send_addr(24'hC0FFEE, 6);
        send_dummy(2);
        for (int i = 0; i < 5; i++) send_word(16'h1357 + 16'(i * 16'h2222));
        end_txn();
        chk("R5 burst event count", 32'(ev_n), 7);
        for (int i = 0; i < 5; i++)
            expect_ev(2 + i, 3, 24'(16'h1357 + 16'(i * 16'h2222)), "R5 burst word");

        // R7: read transaction
        begin_txn();
        send_cmd(8'h83);
        send_addr(24'h0A0B0C, 6);
        chk("R7 oe low after address", 32'(pad_oe), 0);
        send_dummy(1);
        chk("R7 oe low after first dummy", 32'(pad_oe), 0);
        send_dummy(1);
        chk("R7 oe high at data phase", 32'(pad_oe), 1);
        send_word(16'h6666);
        send_word(16'h7777);
        chk("R7 oe held in data phase", 32'(pad_oe), 1);
        #2 cs_n = 1'b1;
        #2 chk("R7 oe drops on deselect", 32'(pad_oe), 0);
        #200;
        chk("R7 read gives no words", 32'(ev_n), 2);
        expect_ev(0, 1, 24'h000083, "R7 read opcode");
        expect_ev(1, 2, 24'h0A0B0C, "R7 read address");

        // R6: abort mid-address, then a clean transaction
        begin_txn();
        send_cmd(8'h11);
        send_addr(24'hFEDCBA, 3);
        end_txn();
        chk("R6 abort in address", 32'(ev_n), 1);
        expect_ev(0, 1, 24'h000011, "R6 opcode before abort");
        begin_txn();
        send_cmd(8'h22);
        send_addr(24'h00ABCD, 6);
        send_dummy(2);
        send_word(16'hBEEF);
        end_txn();
        chk("R6 recovery count", 32'(ev_n), 3);
        expect_ev(0, 1, 24'h000022, "R6 recovery opcode");
        expect_ev(1, 2, 24'h00ABCD, "R6 recovery address");
        expect_ev(2, 3, 24'h00BEEF, "R6 recovery word");

        // R6: abort mid-word
        begin_txn();
        send_cmd(8'h33);
        send_addr(24'h13579B, 6);
        send_dummy(2);
        send_word(16'h4242);
        sck_pulse(4'hC, 4'h3);
        end_txn();
        chk("R6 half word dropped", 32'(ev_n), 3);
        expect_ev(2, 3, 24'h004242, "R6 whole word kept");

        // R9: buses hold, pulses single and exclusive
        chk("R9 cmd held", 32'(cmd_data), 32'h33);
        chk("R9 addr held", 32'(addr_data), 32'h13579B);
        chk("R9 word held", 32'(word_data), 32'h4242);
        chk("R9 strobe shape", 32'(strobe_err), 0);

        // R10: reset mid-run clears, then recovery
        sys_rst_n = 1'b0;
        #20;
        chk("R10 cmd cleared", 32'(cmd_data), 0);
        chk("R10 addr cleared", 32'(addr_data), 0);
        chk("R10 word cleared", 32'(word_data), 0);
        chk("R10 strobes cleared", {29'd0, cmd_valid, addr_valid, word_valid}, 0);
        sys_rst_n = 1'b1;
        #20;
        begin_txn();
        send_cmd(8'h5A);
        send_addr(24'h010203, 6);
        send_dummy(2);
        send_word(16'hC3A5);
        end_txn();
        chk("R10 post-reset count", 32'(ev_n), 3);
        expect_ev(0, 1, 24'h00005A, "R10 post-reset opcode");
        expect_ev(1, 2, 24'h010203, "R10 post-reset address");
        expect_ev(2, 3, 24'h00C3A5, "R10 post-reset word");
        chk("R9 final strobe shape", 32'(strobe_err), 0);

        finish_run();
    end
endmodule